// File: doc/BRIEF.md
# Programmable display timing waveform generator

This block produces the periodic control waveforms that a synchronous display panel expects, such as line sync, frame sync and data-valid, together with a gated pixel clock. A small chain of counters runs on the display clock. The moment a counter steps back to zero is its start point. Each of the seven output pins is tied to one counter. It goes high at a programmed rise offset and low at a programmed fall offset, both measured from the start of that counter's period. Offsets are given in half display-clock units, so an edge can land in either half of a clock cycle.

A counter can be chained so that it advances only when the counter below it wraps. Counter 0 then counts pixels and counter 1 counts lines, and a pin placed on counter 1 has its offsets measured in lines. Configuration is latched into shadow registers when the block starts. After that it is reloaded only at period boundaries, so a change made while the block runs never produces a partial period. A three-state controller, IDLE, LOAD and RUN, sequences start-up and shutdown. Its transitions are: IDLE to LOAD when enable is seen high; LOAD to RUN unconditionally after one cycle; RUN back to IDLE as soon as enable is seen low; and IDLE or RUN holding otherwise.

Top module: `disp_tgen`

## Requirements
- R1: While reset is asserted, and while the controller sits in IDLE, every pin of `pin_o` and `pclk_o` is low in both halves of every clock cycle.
- R2: The first rising edge with `en_i` high moves IDLE to LOAD. LOAD lasts exactly one cycle, in which all configuration is captured, and is followed by RUN. `pclk_o` is a copy of `clk_i` during RUN cycles and is low in every other cycle, including the LOAD cycle.
- R3: With period value P, counter 0 steps every RUN cycle through 0, 1, …, P-1 and then back to 0. Period values 0 and 1 both mean a period of one cycle. Every pin waveform on counter 0 therefore repeats every P clock cycles.
- R4: Let S be the cycle in which the source counter first holds 0 after stepping (or the first RUN cycle). A rise offset u drives the pin high from cycle S+1+floor(u/2) onward. The edge falls in the high half of that cycle when bit 0 of u is 0, and in the low half when bit 0 of u is 1. A fall offset drives the pin low in the same way. For a chained counter, the cycle in which the counter first holds floor(u/2) stands in for S+floor(u/2).
- R5: When a pin's rise and fall offsets are equal, the pin stays low for the whole period.
- R6: Bit k (k ≥ 1) of `cnt_chain_i` set means counter k advances once per wrap of counter k-1. Bit k clear means it advances every cycle. Bit 0 has no effect.
- R7: An offset whose upper bits (u/2) are not below the source counter's period never produces an edge.
- R8: A new period or chain value takes effect at the counter's next wrap. A new pin source or offset takes effect at the next wrap of the pin's current source counter.
- R9: `en_i` seen low during RUN returns the block to IDLE at that edge. From the next cycle on, all pins and `pclk_o` are low, and a later enable restarts from LOAD with fresh configuration.
- R10: A pin's source field value k selects counter k as its time base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Display clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| cnt_period_i | input | NCNT*CW | Period of each counter in steps, counter k at bits [k*CW +: CW] |
| cnt_chain_i | input | NCNT | Bit k set: counter k steps on counter k-1's wrap |
| pin_src_i | input | NPIN*SW | Source counter index per pin |
| pin_up_i | input | NPIN*OW | Rise offset per pin in half clocks |
| pin_dn_i | input | NPIN*OW | Fall offset per pin in half clocks |
| pclk_o | output | 1 | Gated pixel clock |
| pin_o | output | NPIN | Shaped control waveforms |

## Verification
The embedded properties watch behaviour that holds on every cycle:
- the controller's IDLE/LOAD/RUN transitions;
- counters staying inside their period;
- a held period shadow between wraps;
- a chained counter standing still without a wrap below it;
- a pin never rising without an up match;
- equal offsets keeping a pin low.

The bench's scenarios are needed for the things a local property cannot see. These are the exact half-cycle placement of each edge, the number of high halves per period for wrapped, half-phase and line-based waveforms, and the deferral of live configuration changes to the following wrap. They also cover the pixel-clock gating around start-up and shutdown.

// File: rtl/disp_tgen_pkg.sv
package disp_tgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } tg_state_e;

endpackage

// File: rtl/disp_tgen_ctrl.sv
module disp_tgen_ctrl
    import disp_tgen_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic load_o,
    output logic step_o,
    output logic gate_o
);

    tg_state_e st_q, st_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_IDLE;
        else         st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (en_i) st_d = ST_LOAD;
            ST_LOAD: st_d = ST_RUN;
            ST_RUN:  if (!en_i) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_LOAD: load_o = 1'b1;
            ST_RUN:  step_o = en_i;
            default: ;
        endcase
        gate_o = load_o | step_o;
    end

    a_r2_load_then_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_LOAD) |=> (st_q == ST_RUN));

    a_r9_drop_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_RUN && !en_i) |=> (st_q == ST_IDLE));

    a_r1_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_IDLE && !en_i) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/disp_tgen_cnt.sv
module disp_tgen_cnt #(
    parameter int CW        = 10,
    parameter bit CHAINABLE = 1'b0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic          step_i,
    input  logic [CW-1:0] per_i,
    input  logic          chain_i,
    input  logic          parent_wrap_i,
    output logic [CW-1:0] cnt_o,
    output logic          ent_o,
    output logic          wrap_o
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] per_sh_q;
    logic          chain_sh_q;
    logic          ent_q;
    logic          tick;
    logic          last;

    always_comb begin
        tick   = step_i && (!(CHAINABLE && chain_sh_q) || parent_wrap_i);
        last   = (per_sh_q <= CW'(1)) || (cnt_q == per_sh_q - CW'(1));
        wrap_o = tick && last;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q      <= '0;
            ent_q      <= 1'b0;
            per_sh_q   <= '0;
            chain_sh_q <= 1'b0;
        end else if (load_i) begin
            cnt_q      <= '0;
            ent_q      <= 1'b1;
            per_sh_q   <= per_i;
            chain_sh_q <= chain_i;
        end else if (step_i) begin
            if (tick) cnt_q <= last ? '0 : cnt_q + CW'(1);
            ent_q <= tick;
            if (wrap_o) begin
                per_sh_q   <= per_i;
                chain_sh_q <= chain_i;
            end
        end else begin
            cnt_q <= '0;
            ent_q <= 1'b0;
        end
    end

    assign cnt_o = cnt_q;
    assign ent_o = ent_q;

    a_r3_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i |-> ((per_sh_q <= CW'(1)) ? (cnt_q == '0) : (cnt_q < per_sh_q)));

    a_r8_period_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !wrap_o) |=> $stable(per_sh_q));

    if (CHAINABLE) begin : g_chain_chk
        a_r6_hold_without_parent: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (step_i && !tick) |=> $stable(cnt_q));
    end

endmodule

// File: rtl/disp_tgen_pin.sv
module disp_tgen_pin #(
    parameter int NCNT = 2,
    parameter int CW   = 10,
    parameter int OW   = CW + 1,
    parameter int SW   = 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               load_i,
    input  logic               step_i,
    input  logic [SW-1:0]      src_i,
    input  logic [OW-1:0]      up_i,
    input  logic [OW-1:0]      dn_i,
    input  logic [NCNT*CW-1:0] cnt_all_i,
    input  logic [NCNT-1:0]    ent_all_i,
    input  logic [NCNT-1:0]    wrap_all_i,
    output logic               pin_o
);

    logic [SW-1:0] src_sh_q;
    logic [OW-1:0] up_sh_q, dn_sh_q;
    logic          h0_q, s_q, n_q;
    logic [CW-1:0] sel_cnt;
    logic          sel_ent, sel_wrap;
    logic          hit_up, hit_dn, same;
    logic          h0_d, h1_d;

    always_comb begin
        sel_cnt  = '0;
        sel_ent  = 1'b0;
        sel_wrap = 1'b0;
        for (int k = 0; k < NCNT; k++) begin
            if (int'(src_sh_q) == k) begin
                sel_cnt  = cnt_all_i[k*CW +: CW];
                sel_ent  = ent_all_i[k];
                sel_wrap = wrap_all_i[k];
            end
        end
    end

    // level for the high half (h0) and the low half (h1) of the next cycle
    always_comb begin
        hit_up = sel_ent && (sel_cnt == up_sh_q[OW-1:1]);
        hit_dn = sel_ent && (sel_cnt == dn_sh_q[OW-1:1]);
        same   = (up_sh_q == dn_sh_q);
        if (same)                       h0_d = 1'b0;
        else if (hit_up && !up_sh_q[0]) h0_d = 1'b1;
        else if (hit_dn && !dn_sh_q[0]) h0_d = 1'b0;
        else                            h0_d = s_q;
        if (same)                       h1_d = 1'b0;
        else if (hit_up && up_sh_q[0])  h1_d = 1'b1;
        else if (hit_dn && dn_sh_q[0])  h1_d = 1'b0;
        else                            h1_d = h0_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            src_sh_q <= '0;
            up_sh_q  <= '0;
            dn_sh_q  <= '0;
            h0_q     <= 1'b0;
            s_q      <= 1'b0;
        end else if (load_i) begin
            src_sh_q <= src_i;
            up_sh_q  <= up_i;
            dn_sh_q  <= dn_i;
            h0_q     <= 1'b0;
            s_q      <= 1'b0;
        end else if (step_i) begin
            h0_q <= h0_d;
            s_q  <= h1_d;
            if (sel_wrap) begin
                src_sh_q <= src_i;
                up_sh_q  <= up_i;
                dn_sh_q  <= dn_i;
            end
        end else begin
            h0_q <= 1'b0;
            s_q  <= 1'b0;
        end
    end

    // low-half path, captured on the falling edge
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) n_q <= 1'b0;
        else         n_q <= s_q;
    end

    assign pin_o = clk_i ? h0_q : n_q;

    a_r5_equal_stays_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && (up_sh_q == dn_sh_q)) |=> (!h0_q && !s_q));

    a_r4_rise_only_on_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !s_q && !(sel_ent && (sel_cnt == up_sh_q[OW-1:1]))) |=> (!h0_q && !s_q));

endmodule

// File: rtl/disp_tgen.sv
module disp_tgen #(
    parameter int NPIN = 7,
    parameter int NCNT = 2,
    parameter int CW   = 10,
    parameter int OW   = CW + 1,
    parameter int SW   = (NCNT > 1) ? $clog2(NCNT) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  logic [NCNT*CW-1:0] cnt_period_i,
    input  logic [NCNT-1:0]    cnt_chain_i,
    input  logic [NPIN*SW-1:0] pin_src_i,
    input  logic [NPIN*OW-1:0] pin_up_i,
    input  logic [NPIN*OW-1:0] pin_dn_i,
    output logic               pclk_o,
    output logic [NPIN-1:0]    pin_o
);

    logic               load, step, gate;
    logic               gate_q;
    logic [NCNT*CW-1:0] cnt_all;
    logic [NCNT-1:0]    ent_all;
    logic [NCNT-1:0]    wrap_all;

    disp_tgen_ctrl u_ctrl (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .load_o (load),
        .step_o (step),
        .gate_o (gate)
    );

    for (genvar k = 0; k < NCNT; k++) begin : g_cnt
        logic          pw;
        logic          wr;
        logic [CW-1:0] cv;
        logic          ev;
        if (k == 0) begin : g_base
            assign pw = 1'b0;
        end else begin : g_link
            assign pw = g_cnt[k-1].wr;
        end
        disp_tgen_cnt #(
            .CW        (CW),
            .CHAINABLE ((k > 0) ? 1'b1 : 1'b0)
        ) u_cnt (
            .clk_i         (clk_i),
            .rst_ni        (rst_ni),
            .load_i        (load),
            .step_i        (step),
            .per_i         (cnt_period_i[k*CW +: CW]),
            .chain_i       (cnt_chain_i[k]),
            .parent_wrap_i (pw),
            .cnt_o         (cv),
            .ent_o         (ev),
            .wrap_o        (wr)
        );
        assign cnt_all[k*CW +: CW] = cv;
        assign ent_all[k]          = ev;
        assign wrap_all[k]         = wr;
    end

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        disp_tgen_pin #(
            .NCNT (NCNT),
            .CW   (CW),
            .OW   (OW),
            .SW   (SW)
        ) u_pin (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .load_i     (load),
            .step_i     (step),
            .src_i      (pin_src_i[p*SW +: SW]),
            .up_i       (pin_up_i[p*OW +: OW]),
            .dn_i       (pin_dn_i[p*OW +: OW]),
            .cnt_all_i  (cnt_all),
            .ent_all_i  (ent_all),
            .wrap_all_i (wrap_all),
            .pin_o      (pin_o[p])
        );
    end

    // pixel clock enable changes only while the clock is low
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gate_q <= 1'b0;
        else         gate_q <= gate;
    end

    assign pclk_o = clk_i & gate_q;

endmodule

// File: tb/sim_disp_tgen.sv
`timescale 1ns/1ps
module sim_disp_tgen;

    localparam int NP = 7;
    localparam int NC = 2;
    localparam int CW = 10;
    localparam int OW = CW + 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               en = 1'b0;
    logic [NC*CW-1:0]   per = '0;
    logic [NC-1:0]      chain = '0;
    logic [NP-1:0]      src = '0;
    logic [NP*OW-1:0]   up = '0;
    logic [NP*OW-1:0]   dn = '0;
    logic               pclk;
    logic [NP-1:0]      pins;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    disp_tgen u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .en_i         (en),
        .cnt_period_i (per),
        .cnt_chain_i  (chain),
        .pin_src_i    (src),
        .pin_up_i     (up),
        .pin_dn_i     (dn),
        .pclk_o       (pclk),
        .pin_o        (pins)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_st = 0;
    int m_cnt[NC], m_ent[NC], m_per[NC], m_chn[NC];
    int m_up[NP], m_dn[NP], m_src[NP];
    bit m_h0[NP], m_s[NP];
    bit m_gate = 1'b0;

    task automatic model_clear();
        for (int k = 0; k < NC; k++) begin m_cnt[k] = 0; m_ent[k] = 0; end
        for (int p = 0; p < NP; p++) begin m_h0[p] = 0; m_s[p] = 0; end
    endtask

    task automatic model_step();
        bit wr[NC], tk[NC], lst[NC];
        if (!rst_n) begin
            m_st = 0;
            model_clear();
            for (int k = 0; k < NC; k++) begin m_per[k] = 0; m_chn[k] = 0; end
            for (int p = 0; p < NP; p++) begin m_up[p] = 0; m_dn[p] = 0; m_src[p] = 0; end
            return;
        end
        if (m_st == 0) begin
            model_clear();
            if (en) m_st = 1;
        end else if (m_st == 1) begin
            for (int k = 0; k < NC; k++) begin
                m_cnt[k] = 0; m_ent[k] = 1;
                m_per[k] = int'(per[k*CW +: CW]); m_chn[k] = int'(chain[k]);
            end
            for (int p = 0; p < NP; p++) begin
                m_up[p] = int'(up[p*OW +: OW]); m_dn[p] = int'(dn[p*OW +: OW]);
                m_src[p] = int'(src[p]); m_h0[p] = 0; m_s[p] = 0;
            end
            m_st = 2;
        end else if (!en) begin
            model_clear();
            m_st = 0;
        end else begin
            for (int k = 0; k < NC; k++) begin
                tk[k]  = (k == 0 || m_chn[k] == 0) ? 1'b1 : wr[k-1];
                lst[k] = (m_per[k] <= 1) || (m_cnt[k] == m_per[k] - 1);
                wr[k]  = tk[k] && lst[k];
            end
            for (int p = 0; p < NP; p++) begin
                int c;
                bit hu, hd, a, b;
                c  = m_src[p];
                hu = m_ent[c] != 0 && m_cnt[c] == m_up[p] / 2;
                hd = m_ent[c] != 0 && m_cnt[c] == m_dn[p] / 2;
                if (m_up[p] == m_dn[p]) begin
                    a = 0; b = 0;
                end else begin
                    a = m_s[p];
                    if (hu && m_up[p] % 2 == 0) a = 1;
                    else if (hd && m_dn[p] % 2 == 0) a = 0;
                    b = a;
                    if (hu && m_up[p] % 2 == 1) b = 1;
                    else if (hd && m_dn[p] % 2 == 1) b = 0;
                end
                m_h0[p] = a; m_s[p] = b;
                if (wr[c]) begin
                    m_up[p] = int'(up[p*OW +: OW]); m_dn[p] = int'(dn[p*OW +: OW]);
                    m_src[p] = int'(src[p]);
                end
            end
            for (int k = 0; k < NC; k++) begin
                if (tk[k]) m_cnt[k] = lst[k] ? 0 : m_cnt[k] + 1;
                m_ent[k] = tk[k];
                if (wr[k]) begin
                    m_per[k] = int'(per[k*CW +: CW]); m_chn[k] = int'(chain[k]);
                end
            end
        end
    endtask

    // compare both halves of every cycle
    always begin
        logic [NP-1:0] e;
        @(posedge clk);
        model_step();
        #2;
        for (int p = 0; p < NP; p++) e[p] = m_h0[p];
        chk(pins === e, cur_req, "pins high half", int'(pins), int'(e));
        chk(pclk === m_gate, "R2", "pclk high half", int'(pclk), int'(m_gate));
        @(negedge clk);
        m_gate = rst_n && (m_st == 1 || (m_st == 2 && en));
        #2;
        for (int p = 0; p < NP; p++) e[p] = m_s[p];
        chk(pins === e, cur_req, "pins low half", int'(pins), int'(e));
        chk(pclk === 1'b0, "R2", "pclk low half", int'(pclk), 0);
    end

    task automatic set_pin(input int p, input bit s, input int u, input int d);
        src[p] = s;
        up[p*OW +: OW] = OW'(u);
        dn[p*OW +: OW] = OW'(d);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    int hc[NP];

    initial begin
        cycles(5);
        chk(pins === '0, "R1", "pins in reset", int'(pins), 0);
        chk(pclk === 1'b0, "R1", "pclk in reset", int'(pclk), 0);
        rst_n = 1'b1;
        cycles(4);
        chk(pins === '0, "R1", "pins idle", int'(pins), 0);

        per[0*CW +: CW] = 10'd10;
        per[1*CW +: CW] = 10'd4;
        chain = 2'b10;               // R6: counter 1 counts lines
        set_pin(0, 0, 0, 4);         // R4 whole-clock edges
        set_pin(1, 0, 3, 8);         // R4 half-clock rise
        set_pin(2, 0, 5, 5);         // R5
        set_pin(3, 1, 2, 4);         // R6 one line high
        set_pin(4, 0, 30, 2);        // R7 rise beyond period
        set_pin(5, 0, 14, 2);        // R3 high across the wrap
        set_pin(6, 1, 0, 1);         // R10 source 1
        cur_req = "R2";
        en = 1'b1;
        @(posedge clk); #3;
        chk(pclk === 1'b0, "R2", "pclk in LOAD", int'(pclk), 0);
        @(posedge clk); #3;
        chk(pclk === 1'b1, "R2", "pclk first RUN", int'(pclk), 1);
        cur_req = "R4";
        cycles(50);

        for (int p = 0; p < NP; p++) hc[p] = 0;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #3;
            for (int p = 0; p < NP; p++) hc[p] += int'(pins[p]);
            @(negedge clk); #3;
            for (int p = 0; p < NP; p++) hc[p] += int'(pins[p]);
        end
        chk(hc[0] == 16, "R4", "pin0 high halves", hc[0], 16);
        chk(hc[1] == 20, "R4", "pin1 high halves", hc[1], 20);
        chk(hc[2] == 0,  "R5", "pin2 high halves", hc[2], 0);
        chk(hc[3] == 20, "R6", "pin3 high halves", hc[3], 20);
        chk(hc[4] == 0,  "R7", "pin4 high halves", hc[4], 0);
        chk(hc[5] == 32, "R3", "pin5 high halves", hc[5], 32);
        chk(hc[6] == 1,  "R10", "pin6 high halves", hc[6], 1);

        cycles(3);
        cur_req = "R8";
        per[0*CW +: CW] = 10'd6;
        set_pin(0, 0, 2, 7);
        cycles(60);

        cur_req = "R6";
        chain = 2'b00;
        cycles(30);

        cur_req = "R9";
        en = 1'b0;
        @(posedge clk); #3;
        chk(pins === '0, "R9", "pins after drop", int'(pins), 0);
        chk(pclk === 1'b0, "R9", "pclk after drop", int'(pclk), 0);
        cur_req = "R1";
        cycles(6);
        cur_req = "R9";
        chain = 2'b10;
        en = 1'b1;
        cycles(40);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule